// File: doc/BRIEF.md
# Transmit Abort Path with Deliberate FCS Corruption

This block sits on the byte-wide transmit path between the frame source and the line. While a frame passes through, it forwards each byte one cycle later and keeps a running CRC-32 over everything it has put on the line. At a normal frame end it appends the four-byte frame check sequence. The source marks the first byte of a frame with a start flag and the final byte with a last flag.

When a fatal system error raises the abort input during a frame body, the block ends the frame cleanly on a byte boundary. A saturating tally records how many bits of the frame have left. If that tally is below the minimum-frame threshold, the line goes quiet on the very next cycle and the frame becomes a runt. Otherwise the block appends the running CRC in its bitwise-inverted form, so that any receiver is guaranteed to flag an FCS error. In both cases the block then ignores the source until a new frame start, and it pulses a completion flag in the first idle cycle after any frame ends.

Top module: `tx_abort_fcs`

## Requirements
- R1: After reset `m_valid` and `m_done` are low, and they stay low until a frame starts.
- R2: While idle, a byte with `s_valid` and `s_sof` high starts a frame and appears unchanged on `m_data` with `m_valid` high one cycle later. Idle bytes without `s_sof` produce no output.
- R3: In a frame body every valid byte appears unchanged on `m_data` one cycle later. A cycle with `s_valid` low gives a cycle with `m_valid` low, and the frame stays open.
- R4: After a byte flagged `s_last`, four further bytes follow back to back. Together they are the ones' complement of the CRC-32 over all data bytes sent in the frame, least significant byte first. The CRC is reflected, uses polynomial 0x04C11DB7 (0xEDB88320 in reflected form), starts at all ones and takes each byte's bit 0 first.
- R5: An abort in the frame body with fewer than 512 bits sent (fewer than 64 bytes already on the line) makes `m_valid` low on the next cycle, and no FCS is sent. A byte offered in the abort cycle is dropped. This holds whether `s_valid` is high or low in that cycle.
- R6: An abort in the frame body with 512 or more bits sent makes four bytes follow on the next four cycles, back to back. They hold the running CRC itself, which is the R4 FCS with every bit inverted, least significant byte first.
- R7: The bit tally restarts at each frame start and saturates at the threshold. An abort after exactly 63 bytes gives a runt. An abort after exactly 64 bytes, or after any longer run, gives the inverted FCS.
- R8: `m_done` is high for exactly one cycle, the first cycle in which `m_valid` is low after a frame ends (normal end, runt abort or inverted-FCS abort).
- R9: An abort while idle, or while FCS bytes are being sent, has no effect. While FCS bytes are sent and after a frame ends, data bytes are ignored until the next byte carrying `s_sof`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| s_valid | input | 1 | Source byte present this cycle |
| s_data | input | 8 | Source byte |
| s_sof | input | 1 | Byte is the first of a frame |
| s_last | input | 1 | Byte is the final data byte of a frame |
| abort_req | input | 1 | Fatal-error abort pulse |
| m_valid | output | 1 | Line byte present |
| m_data | output | 8 | Line byte |
| m_done | output | 1 | One-cycle pulse in the first idle cycle after a frame ends |

## Verification
The assertions assume that every input is synchronous to `clk` and is sampled only at the rising edge. They also assume that `s_sof` and `s_last` mean something only when `s_valid` is high, and that the source never holds a frame open while it waits for the block. The stimulus drives all inputs on the falling edge, so every value is stable at the sampling edge. It also offers stray bytes and aborts during the idle and FCS phases on purpose, because those phases must ignore them. Aborts are placed on either side of the 64-byte threshold and well beyond it, which exercises the runt decision, the inverted-FCS decision and the saturated tally.

// File: rtl/tx_abort_pkg.sv
package tx_abort_pkg;

    // Reflected form of the 802.3 CRC-32 generator and its preset value
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_PRESET    = 32'hFFFFFFFF;

    typedef enum logic [1:0] {
        ST_IDLE,   // waiting for a frame start
        ST_BODY,   // forwarding data bytes
        ST_FCS,    // emitting check bytes (true or poisoned)
        ST_CLOSE   // first quiet cycle after FCS, completion pulse
    } tx_state_e;

endpackage

// File: rtl/tx_crc32_byte.sv
module tx_crc32_byte
    import tx_abort_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [31:0]       crc_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [31:0]       crc_out
);

    // One shift stage per data bit, bit 0 of the beat first
    logic [DATA_W:0][31:0] stage;

    assign stage[0] = crc_in;

    generate
        for (genvar b = 0; b < DATA_W; b++) begin : g_bit
            logic feedback;
            assign feedback     = stage[b][0] ^ data_in[b];
            assign stage[b + 1] = (stage[b] >> 1) ^ (feedback ? CRC_POLY_REFL : 32'h0);
        end
    endgenerate

    assign crc_out = stage[DATA_W];

endmodule

// File: rtl/tx_bit_tally.sv
module tx_bit_tally #(
    parameter int MIN_BITS  = 512,
    parameter int STEP_BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,     // first beat of a frame: tally restarts at one beat
    input  logic step,     // one more beat has gone out
    output logic reached   // tally has hit the threshold
);

    localparam int CNT_W = $clog2(MIN_BITS + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W:0]   sum;

    always_comb begin
        sum   = {1'b0, cnt_q} + (CNT_W + 1)'(STEP_BITS);
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = CNT_W'(STEP_BITS);
        end else if (step) begin
            cnt_d = (sum >= (CNT_W + 1)'(MIN_BITS)) ? CNT_W'(MIN_BITS) : sum[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign reached = (cnt_q >= CNT_W'(MIN_BITS));

    // R7: saturation never lets the tally pass the threshold
    a_r7_tally_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(MIN_BITS));

    // R7: once reached, further beats keep the threshold reached
    a_r7_tally_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (reached && step && !load) |=> reached);

endmodule

// File: rtl/tx_abort_fcs.sv
module tx_abort_fcs
    import tx_abort_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int MIN_BITS = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_sof,
    input  logic              s_last,
    input  logic              abort_req,
    output logic              m_valid,
    output logic [DATA_W-1:0] m_data,
    output logic              m_done
);

    localparam int FCS_BEATS = 32 / DATA_W;
    localparam int IDX_W     = (FCS_BEATS > 1) ? $clog2(FCS_BEATS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FCS_BEATS - 1);

    typedef struct packed {
        tx_state_e         st;
        logic [31:0]       crc;
        logic [IDX_W-1:0]  idx;
        logic              inv;
        logic              vld;
        logic [DATA_W-1:0] dat;
        logic              done;
    } regs_t;

    localparam regs_t REGS_RESET = '{
        st:   ST_IDLE,
        crc:  CRC_PRESET,
        idx:  '0,
        inv:  1'b0,
        vld:  1'b0,
        dat:  '0,
        done: 1'b0
    };

    regs_t r_d, r_q;

    logic [31:0] crc_seed, crc_next, fcs_word, fcs_shift;
    logic        tally_load, tally_step, tally_reached;

    // A new frame starts from the preset; otherwise continue the running value
    assign crc_seed = (r_q.st == ST_IDLE) ? CRC_PRESET : r_q.crc;

    tx_crc32_byte #(
        .DATA_W (DATA_W)
    ) i_crc (
        .crc_in  (crc_seed),
        .data_in (s_data),
        .crc_out (crc_next)
    );

    tx_bit_tally #(
        .MIN_BITS  (MIN_BITS),
        .STEP_BITS (DATA_W)
    ) i_tally (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tally_load),
        .step    (tally_step),
        .reached (tally_reached)
    );

    // True FCS is the complement of the register; the poisoned one is the register itself
    assign fcs_word  = r_q.inv ? r_q.crc : ~r_q.crc;
    assign fcs_shift = fcs_word >> (32'(r_q.idx) * DATA_W);

    always_comb begin
        r_d        = r_q;
        r_d.vld    = 1'b0;
        r_d.done   = 1'b0;
        tally_load = 1'b0;
        tally_step = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (s_valid && s_sof) begin
                    r_d.vld    = 1'b1;
                    r_d.dat    = s_data;
                    r_d.crc    = crc_next;
                    r_d.inv    = 1'b0;
                    r_d.idx    = '0;
                    tally_load = 1'b1;
                    r_d.st     = s_last ? ST_FCS : ST_BODY;
                end
            end

            ST_BODY: begin
                if (abort_req) begin
                    if (tally_reached) begin
                        // Poisoned FCS starts on the next beat boundary
                        r_d.vld = 1'b1;
                        r_d.dat = r_q.crc[DATA_W-1:0];
                        r_d.inv = 1'b1;
                        r_d.idx = IDX_W'(1);
                        r_d.st  = ST_FCS;
                    end else begin
                        // Runt: the line falls quiet at once
                        r_d.done = 1'b1;
                        r_d.st   = ST_IDLE;
                    end
                end else if (s_valid) begin
                    r_d.vld    = 1'b1;
                    r_d.dat    = s_data;
                    r_d.crc    = crc_next;
                    tally_step = 1'b1;
                    if (s_last) begin
                        r_d.inv = 1'b0;
                        r_d.idx = '0;
                        r_d.st  = ST_FCS;
                    end
                end
            end

            ST_FCS: begin
                r_d.vld = 1'b1;
                r_d.dat = fcs_shift[DATA_W-1:0];
                if (r_q.idx == LAST_IDX) begin
                    r_d.st = ST_CLOSE;
                end else begin
                    r_d.idx = r_q.idx + IDX_W'(1);
                end
            end

            ST_CLOSE: begin
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end

            default: r_d = REGS_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= REGS_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign m_valid = r_q.vld;
    assign m_data  = r_q.dat;
    assign m_done  = r_q.done;

    // R5: a short-frame abort silences the line and closes the frame next cycle
    a_r5_runt_cut: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_BODY && abort_req && !tally_reached) |=> (!m_valid && m_done));

    // R6: a long-frame abort keeps the line busy with poisoned check bytes
    a_r6_poison_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_BODY && abort_req && tally_reached) |=> (m_valid && !m_done));

    // R4: check bytes leave back to back
    a_r4_fcs_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_FCS) |=> m_valid);

    // R8: completion pulse only on a quiet line
    a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        m_done |-> !m_valid);

    // R8: completion pulse lasts one cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        m_done |=> !m_done);

    // R9: idle without a frame start produces nothing
    a_r9_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && !(s_valid && s_sof)) |=> !m_valid);

endmodule

// File: tb/test_tx_abort_fcs.sv
`timescale 1ns/1ps
module test_tx_abort_fcs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       s_valid = 1'b0;
    logic [7:0] s_data = 8'h00;
    logic       s_sof = 1'b0;
    logic       s_last = 1'b0;
    logic       abort_req = 1'b0;
    logic       m_valid;
    logic [7:0] m_data;
    logic       m_done;

    always #4 clk = ~clk;   // 125 MHz

    tx_abort_fcs i_tx_abort_fcs (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_valid   (s_valid),
        .s_data    (s_data),
        .s_sof     (s_sof),
        .s_last    (s_last),
        .abort_req (abort_req),
        .m_valid   (m_valid),
        .m_data    (m_data),
        .m_done    (m_done)
    );

    int    vectors = 0;
    int    miscompares = 0;
    string tag = "R1";

    // Behavioural reference: mode 0 idle, 1 body, 2 check bytes, 3 closing
    int          md = 0;
    int          mbits = 0;
    logic [31:0] mcrc = 32'hFFFFFFFF;
    logic [7:0]  fq[$];
    logic        ev = 1'b0;
    logic [7:0]  ed = 8'h00;
    logic        edone = 1'b0;

    function automatic logic [31:0] crc_upd(logic [31:0] c, logic [7:0] b);
        for (int k = 0; k < 8; k++) begin
            if (c[0] ^ b[k]) c = (c >> 1) ^ 32'hEDB88320;
            else             c = c >> 1;
        end
        return c;
    endfunction

    task automatic push_word(logic [31:0] w);
        for (int k = 0; k < 4; k++) fq.push_back(w[8*k +: 8]);
    endtask

    task automatic model_step();
        ev    = 1'b0;
        edone = 1'b0;
        if (!rst_n) begin
            md = 0;
            fq.delete();
            return;
        end
        case (md)
            0: if (s_valid && s_sof) begin
                ev    = 1'b1;
                ed    = s_data;
                mcrc  = crc_upd(32'hFFFFFFFF, s_data);
                mbits = 8;
                if (s_last) begin push_word(~mcrc); md = 2; end
                else md = 1;
            end
            1: if (abort_req) begin
                if (mbits >= 512) begin
                    push_word(mcrc);
                    ev = 1'b1;
                    ed = fq.pop_front();
                    md = 2;
                end else begin
                    edone = 1'b1;
                    md    = 0;
                end
            end else if (s_valid) begin
                ev    = 1'b1;
                ed    = s_data;
                mcrc  = crc_upd(mcrc, s_data);
                mbits = mbits + 8;
                if (s_last) begin push_word(~mcrc); md = 2; end
            end
            2: begin
                ev = 1'b1;
                ed = fq.pop_front();
                if (fq.size() == 0) md = 3;
            end
            default: begin
                edone = 1'b1;
                md    = 0;
            end
        endcase
    endtask

    task automatic compare();
        vectors++;
        if ((m_valid !== ev) || (m_done !== edone) || (ev && (m_data !== ed))) begin
            miscompares++;
            $display("FAIL %s t=%0t: valid %b exp %b, data %02h exp %02h, done %b exp %b",
                     tag, $time, m_valid, ev, m_data, ed, m_done, edone);
        end
    endtask

    task automatic cyc(logic v, logic sof, logic last, logic ab, logic [7:0] d);
        s_valid   = v;
        s_sof     = sof;
        s_last    = last;
        abort_req = ab;
        s_data    = d;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    endtask

    // n data bytes; abort offered in place of byte abort_at (-1: none); gap before byte gap_at
    task automatic send(int n, int abort_at, int gap_at, int seed, string t);
        tag = t;
        for (int i = 0; i < n; i++) begin
            if (i == gap_at) cyc(1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
            if (i == abort_at) begin
                cyc(1'b1, i == 0, 1'b0, 1'b1, 8'(i * 37 + seed));
                break;
            end
            cyc(1'b1, i == 0, i == n - 1, 1'b0, 8'(i * 37 + seed));
        end
        idle(7);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not finish, actual hung, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: quiet during and after reset
        tag = "R1";
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 8'hA5);
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        rst_n = 1'b1;
        idle(2);

        // R9: stray bytes and an abort while idle produce nothing
        tag = "R9";
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h11);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 8'h22);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
        idle(2);

        // R2 / R4: single-byte frame
        send(1, -1, -1, 8'h5C, "R2");
        // R3 / R4: short frame with a gap
        send(10, -1, 4, 3, "R3");
        send(17, -1, -1, 91, "R4");
        // R8: completion after a normal end, checked on every cycle
        send(6, -1, -1, 200, "R8");

        // R5: runt abort with a byte offered in the abort cycle
        send(30, 20, -1, 7, "R5");
        // R5: runt abort with no byte offered, then stray data ignored (R9)
        tag = "R5";
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 8'h31);
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h32);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
        tag = "R9";
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h33);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 8'h34);
        idle(3);

        // R7: threshold boundary on both sides, then saturation
        send(70, 63, -1, 13, "R7");
        send(70, 64, -1, 29, "R7");
        send(130, 100, -1, 41, "R6");
        send(90, 65, 30, 77, "R6");

        // R2: new frame right after a runt abort
        tag = "R2";
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 8'h40);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 8'h41);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 8'h42);
        // R9: abort and data during the check bytes are ignored
        tag = "R9";
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 8'h43);
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h44);
        idle(6);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule